// File: doc/BRIEF.md
# Unlock-Guarded Reset Control Registers

This block holds the reset configuration registers that software uses, and it guards them with an unlock code. A 32-bit register bus reaches three word locations. The first is a command word that carries a 16-bit key and a software reset bit. The second is a setup word that chooses a hard or a soft reset for the external pin, for the clock-synthesizer controller and for each watchdog. The third is a read-only cause word. It shows which source produced the latest reset.

Software must first write the unlock code 0x5A69 into the key field. It may then make exactly one change to the command word or the setup word, and the block locks again after that write. A software reset request leaves the block as a single-cycle pulse. Reset-event pulses arrive from the pin, from the synthesizer controller and from the watchdogs, and each one replaces the cause word with the flag for that source. The active-low `rst_n` input is the power-on reset. It returns every register to its default and marks power-on as the cause.

Top module: `rstkey_regs`

## Requirements
- R1: Out of power-on reset, the command word reads 0x0001_0003, the setup word reads 0, the cause word reads 0x0000_0001, and `swrst_req` and all type outputs are 0.
- R2: A command-word write made while locked unlocks the block only if bits 15:0 equal 0x5A69. While the block is unlocked, bits 15:0 of the command word read 0x000C, and while it is locked they read 0x0003. An unlocking write ignores bit 16.
- R3: Any write to the command word (address 0) or the setup word (address 1) made while unlocked locks the block again, so every protected change needs its own unlock. A write to the cause word does not lock the block.
- R4: A command-word write made while unlocked with bit 16 = 0 raises `swrst_req` for exactly one cycle, starting at the write's clock edge. During that cycle bit 16 reads 0, and afterwards it reads 1. If bit 16 = 1, no pulse is produced.
- R5: A setup-word write made while unlocked stores bit 13 (synthesizer controller), bit 12 (pin) and bits NUM_WD-1:0 (watchdog i at bit i). In each bit, 1 selects a soft reset and 0 selects a hard reset. The bits drive `type_pll`, `type_pin` and `type_wd`. All other setup bits read 0.
- R6: A setup-word write made while locked leaves the setup word and the type outputs unchanged.
- R7: On a reset event, the cause word clears every earlier flag and sets only the new one: bit 1 for the pin, bit 2 for the synthesizer controller, and bit 8+i for watchdog i. Exactly one cause bit is ever set.
- R8: When several events arrive in the same cycle, the pin wins, then the synthesizer controller, then the watchdog with the lowest index.
- R9: Writes to the cause word (address 2) have no effect, and its reserved bits (7:3 and 31:12) read 0.
- R10: Read data is combinational from `bus_addr` in the same cycle: address 0 gives the command word, 1 the setup word, 2 the cause word, and any other address gives 0.
- R11: Asserting `rst_n` at any time restores the R1 state, including the power-on flag in the cause word.
- R12: Reset events change neither the setup word nor the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ev_pin | input | 1 | External pin reset event pulse |
| ev_pll | input | 1 | Synthesizer-controller reset event pulse |
| ev_wd | input | NUM_WD | Watchdog reset event pulses |
| swrst_req | output | 1 | Single-cycle software reset request |
| type_pin | output | 1 | Pin reset type, 1 = soft |
| type_pll | output | 1 | Synthesizer-controller reset type, 1 = soft |
| type_wd | output | NUM_WD | Per-watchdog reset type, 1 = soft |

## Verification
The assertions assume that `bus_wr` and the event inputs are synchronous to `clk` and stable around its rising edge. They also assume that `rst_n` is the only thing that clears the block, so the only sources of `swrst_req` are a write or reset. The stimulus drives every input shortly after the falling edge and holds it across the next rising edge. It applies events both alone and in simultaneous combinations, and it mixes valid keys, invalid keys and unmapped addresses in a long randomized phase. Power-on reset is asserted mid-run for whole cycles only, so the assertions simply restart once it is released.

// File: rtl/rstkey_regs.sv
module rstkey_regs #(
  parameter int NUM_WD = 4,
  parameter int AW = 4,
  parameter logic [15:0] KEY_CODE = 16'h5A69,
  parameter logic [15:0] KEY_OPEN = 16'h000C,
  parameter logic [15:0] KEY_SHUT = 16'h0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_pin,
  input  logic              ev_pll,
  input  logic [NUM_WD-1:0] ev_wd,
  output logic              swrst_req,
  output logic              type_pin,
  output logic              type_pll,
  output logic [NUM_WD-1:0] type_wd
);
  localparam int SW = 3 + NUM_WD;
  localparam logic [AW-1:0] A_CMD = AW'(0);
  localparam logic [AW-1:0] A_CFG = AW'(1);
  localparam logic [AW-1:0] A_CAU = AW'(2);

  logic          unlocked;
  logic [SW-1:0] status_q;
  logic [SW-1:0] evt_next;
  logic          evt_hit;

  wire wr_cmd = bus_wr && (bus_addr == A_CMD);
  wire wr_cfg = bus_wr && (bus_addr == A_CFG);

  assign evt_hit = ev_pin | ev_pll | (|ev_wd);

  always_comb begin
    evt_next = '0;
    if (ev_pin) evt_next[1] = 1'b1;
    else if (ev_pll) evt_next[2] = 1'b1;
    else
      for (int i = NUM_WD - 1; i >= 0; i--)
        if (ev_wd[i]) begin
          evt_next = '0;
          evt_next[3+i] = 1'b1;
        end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked  <= 1'b0;
      swrst_req <= 1'b0;
      type_pin  <= 1'b0;
      type_pll  <= 1'b0;
      type_wd   <= '0;
      status_q  <= SW'(1);
    end else begin
      swrst_req <= 1'b0;
      if (wr_cmd) begin
        if (unlocked) begin
          unlocked  <= 1'b0;
          swrst_req <= ~bus_wdata[16];
        end else if (bus_wdata[15:0] == KEY_CODE) begin
          unlocked <= 1'b1;
        end
      end
      if (wr_cfg) begin
        unlocked <= 1'b0;
        if (unlocked) begin
          type_pll <= bus_wdata[13];
          type_pin <= bus_wdata[12];
          type_wd  <= bus_wdata[NUM_WD-1:0];
        end
      end
      if (evt_hit) status_q <= evt_next;
    end
  end

  logic [31:0] rd_cmd, rd_cfg, rd_cau;

  assign rd_cmd = {15'b0, ~swrst_req, unlocked ? KEY_OPEN : KEY_SHUT};

  always_comb begin
    rd_cfg = '0;
    rd_cfg[13] = type_pll;
    rd_cfg[12] = type_pin;
    rd_cfg[NUM_WD-1:0] = type_wd;
    rd_cau = '0;
    rd_cau[2:0] = status_q[2:0];
    rd_cau[8 +: NUM_WD] = status_q[SW-1:3];
  end

  assign bus_rdata = (bus_addr == A_CMD) ? rd_cmd :
                     (bus_addr == A_CFG) ? rd_cfg :
                     (bus_addr == A_CAU) ? rd_cau : 32'h0;

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:17], bus_wdata[11:NUM_WD]};
endmodule

// File: rtl/rstkey_regs_chk.sv
module rstkey_regs_chk #(
  parameter int NUM_WD = 4,
  parameter int AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              unlocked,
  input logic              swrst_req,
  input logic              ev_pin,
  input logic              type_pin,
  input logic              type_pll,
  input logic [NUM_WD-1:0] type_wd,
  input logic [NUM_WD+2:0] status_q
);
  a_r7_single_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(status_q));

  a_r7_pin_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pin |=> status_q[1]);

  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_req |=> !swrst_req);

  a_r4_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_req |-> $past(bus_wr && bus_addr == AW'(0) && unlocked && !bus_wdata[16]));

  a_r3_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == AW'(0) || bus_addr == AW'(1)) && unlocked) |=> !unlocked);

  a_r6_cfg_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == AW'(1) && unlocked) |=> $stable({type_pin, type_pll, type_wd}));
endmodule

bind rstkey_regs rstkey_regs_chk #(.NUM_WD(NUM_WD), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .unlocked(unlocked), .swrst_req(swrst_req),
  .ev_pin(ev_pin), .type_pin(type_pin), .type_pll(type_pll),
  .type_wd(type_wd), .status_q(status_q)
);

// File: tb/rstkey_regs_tb_top.sv
`timescale 1ns/1ps
module rstkey_regs_tb_top;
  localparam int NW = 4;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0, bus_wr = 0, ev_pin = 0, ev_pll = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NW-1:0] ev_wd = '0, type_wd;
  logic swrst_req, type_pin, type_pll;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rstkey_regs #(.NUM_WD(NW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pin(ev_pin),
    .ev_pll(ev_pll), .ev_wd(ev_wd), .swrst_req(swrst_req),
    .type_pin(type_pin), .type_pll(type_pll), .type_wd(type_wd));

  // reference model
  bit m_open, m_req;
  logic [31:0] m_cfg, m_cause;

  function automatic logic [31:0] m_read(logic [AW-1:0] a);
    if (a == 0) return {15'b0, !m_req, m_open ? 16'h000C : 16'h0003};
    if (a == 1) return m_cfg;
    if (a == 2) return m_cause;
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_open = 0; m_req = 0; m_cfg = 0; m_cause = 32'h1;
    end else begin
      m_req = 0;
      if (bus_wr && bus_addr == 0) begin
        if (m_open) begin m_open = 0; m_req = !bus_wdata[16]; end
        else if (bus_wdata[15:0] == 16'h5A69) m_open = 1;
      end
      if (bus_wr && bus_addr == 1) begin
        if (m_open) m_cfg = bus_wdata & 32'h0000_300F;
        m_open = 0;
      end
      if (ev_pin) m_cause = 32'h2;
      else if (ev_pll) m_cause = 32'h4;
      else if (ev_wd != 0) begin
        for (int i = NW - 1; i >= 0; i--) if (ev_wd[i]) m_cause = 32'h100 << i;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R10 cycle read", bus_rdata, m_read(bus_addr));
    chk("R4 cycle req", {31'b0, swrst_req}, {31'b0, m_req});
    chk("R5 cycle types", {26'b0, type_pll, type_pin, type_wd},
        {26'b0, m_cfg[13], m_cfg[12], m_cfg[3:0]});
  end

  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
    @(negedge clk); #1; bus_wr = 0; bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); #1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1; bus_wr = 0;
  endtask

  task automatic ev(logic p, logic l, logic [NW-1:0] w);
    @(negedge clk); #1; ev_pin = p; ev_pll = l; ev_wd = w;
    @(negedge clk); #1; ev_pin = 0; ev_pll = 0; ev_wd = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rd(0, 32'h0001_0003, "R1 cmd");
    rd(1, 32'h0, "R1 cfg");
    rd(2, 32'h1, "R1 cause");
    chk("R1 outputs", {26'b0, swrst_req, type_pin, type_pll, type_wd}, 32'h0);
    #1; rst_n = 1;
    rd(0, 32'h0001_0003, "R1 after release");

    wr(0, 32'h0000_1234);
    rd(0, 32'h0001_0003, "R2 bad key stays locked");
    wr(1, 32'h0003_000F);
    rd(1, 32'h0, "R6 locked cfg write");
    wr(0, 32'h0000_5A69);
    chk("R2 unlock ignores bit16", {31'b0, swrst_req}, 32'h0);
    rd(0, 32'h0001_000C, "R2 open key");
    wr(1, 32'hFFFF_FFFF);
    rd(1, 32'h0000_300F, "R5 cfg stored");
    chk("R5 types", {26'b0, type_pll, type_pin, type_wd}, 32'h3F);
    rd(0, 32'h0001_0003, "R3 relock after cfg");
    wr(1, 32'h0);
    rd(1, 32'h0000_300F, "R6 cfg unchanged");

    wr(0, 32'h0000_5A69);
    @(negedge clk); #1; bus_wr = 1; bus_addr = 0; bus_wdata = 32'h0;
    @(negedge clk); #1; bus_wr = 0;
    chk("R4 pulse high", {31'b0, swrst_req}, 32'h1);
    chk("R4 bit16 reads 0", bus_rdata, 32'h0000_0003);
    @(negedge clk); #1;
    chk("R4 pulse ends", {31'b0, swrst_req}, 32'h0);
    rd(0, 32'h0001_0003, "R4 bit16 back, R3 relocked");

    wr(0, 32'h0000_5A69);
    wr(0, 32'h0001_0000);
    chk("R4 no pulse with bit16=1", {31'b0, swrst_req}, 32'h0);
    rd(0, 32'h0001_0003, "R3 relock after cmd");

    wr(0, 32'h0000_5A69);
    wr(2, 32'hFFFF_FFFF);
    rd(2, 32'h1, "R9 cause write ignored");
    rd(0, 32'h0001_000C, "R3 cause write keeps open");
    wr(1, 32'h0000_2004);
    rd(1, 32'h0000_2004, "R5 partial cfg");

    ev(1, 0, 0); rd(2, 32'h2, "R7 pin");
    ev(0, 1, 0); rd(2, 32'h4, "R7 pll");
    for (int i = 0; i < NW; i++) begin
      ev(0, 0, NW'(1) << i);
      rd(2, 32'h100 << i, "R7 watchdog");
    end
    ev(0, 1, 4'b0010); rd(2, 32'h4, "R8 pll over wd");
    ev(0, 0, 4'b1010); rd(2, 32'h200, "R8 low wd wins");
    ev(1, 1, 4'b1111); rd(2, 32'h2, "R8 pin first");
    rd(3, 32'h0, "R10 unmapped");
    rd(1, 32'h0000_2004, "R12 cfg kept");
    wr(0, 32'h0000_5A69);
    ev(0, 0, 4'b0001);
    rd(0, 32'h0001_000C, "R12 lock kept");
    wr(0, 32'h0001_0000);

    for (int n = 0; n < 600; n++) begin
      @(negedge clk); #1;
      bus_wr = ($urandom % 2) == 0;
      bus_addr = AW'($urandom % 5);
      bus_wdata = $urandom;
      if (($urandom % 3) == 0) bus_wdata[15:0] = 16'h5A69;
      ev_pin = ($urandom % 23) == 0;
      ev_pll = ($urandom % 19) == 0;
      ev_wd = (($urandom % 7) == 0) ? NW'($urandom) : '0;
    end
    @(negedge clk); #1; bus_wr = 0; ev_pin = 0; ev_pll = 0; ev_wd = 0;

    wr(0, 32'h0000_5A69);
    wr(1, 32'h0000_300F);
    ev(0, 0, 4'b0100);
    @(negedge clk); #1; rst_n = 0;
    repeat (2) @(negedge clk);
    #1; rst_n = 1;
    rd(0, 32'h0001_0003, "R11 cmd");
    rd(1, 32'h0, "R11 cfg");
    rd(2, 32'h1, "R11 cause");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule